// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block is the master-side bit engine of an I2C controller. A single start pulse makes it clock one data item of 1 to 8 bits over SDA. It either shifts the item out, most significant bit first, or samples it in from the addressed device. An optional acknowledge clock pulse can follow the data. Start and stop conditions, arbitration and slave operation belong to other logic.

SCL is generated from the reference clock. A 3-bit rate code picks a power-of-two low phase, and the high phase is always four reference cycles longer than the low phase. Both bus lines are open-drain. Each one is modelled as an output enable that pulls the line low, together with an input that reads the wired line back. While a high phase runs, the engine waits for the SCL line to actually rise. A device that holds SCL low therefore stretches the clock.

Top module: `i2c_xfer_engine`

## Requirements
- R1: A start pulse while idle makes busy and the SCL pull-down go high in the next cycle. A start pulse while busy is ignored: it neither alters nor restarts the transfer.
- R2: The bit-count field value 0 selects 8 bits, and values 1 to 7 select that many bits. As transmitter, the engine sends the top k bits of the data byte, bit 7 first.
- R3: As receiver, SDA is sampled in the first reference cycle of each SCL high phase in which SCL reads high. Each new bit shifts into bit 0 of the received byte, so that after k bits, bits k-1..0 hold them (first received in bit k-1) and the upper bits read 0.
- R4: With acknowledge enabled, one extra SCL pulse follows the data. As transmitter, the engine releases SDA and stores the SDA level sampled on that pulse as the acknowledge bit. As receiver, it pulls SDA low for that pulse.
- R5: With acknowledge disabled, no extra pulse is issued, and the acknowledge bit output reads 1 after the transfer. The acknowledge output is set to 1 at every accepted start.
- R6: Rate code c in 0..6 gives a low phase of L = 2^(c+3) reference cycles and a high phase of L+4. Code 7 behaves as code 6.
- R7: With P pulses (data bits plus acknowledge), busy stays high for P*(2L+4)+L cycles: each pulse is a low phase and a high phase, followed by one closing low phase. Done is high for exactly one cycle, the first cycle in which busy is low.
- R8: The SDA pull-down changes only in cycles in which SCL is pulled low. While idle, both lines are released.
- R9: During a high phase, the phase timer holds while SCL reads low, so a stretch of S cycles lengthens the transfer by exactly S cycles.
- R10: Direction, data, bit count, acknowledge enable and rate code are captured at the accepted start. Changing them during a transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start one data item (taken only when idle) |
| rx_dir_i | input | 1 | 1 = receive, 0 = transmit |
| tx_byte_i | input | 8 | Data to send, top bits first |
| bit_cnt_i | input | 3 | Bits per item, 0 means 8 |
| ack_en_i | input | 1 | Add an acknowledge clock pulse |
| clk_sel_i | input | 3 | SCL rate code |
| sda_i | input | 1 | Wired SDA level |
| scl_i | input | 1 | Wired SCL level |
| sda_oe_o | output | 1 | Pull SDA low |
| scl_oe_o | output | 1 | Pull SCL low |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_byte_o | output | 8 | Received bits, right-aligned |
| ack_bit_o | output | 1 | Sampled acknowledge level |

## Verification
Every result of a transfer is due at the done pulse. That pulse comes P*(2L+4)+L cycles after the start edge, plus any stretch cycles. The driver computes this count from the rate code, the bit count and the acknowledge setting, and queues it with the expected data, acknowledge level and number of SCL pulses. The monitor counts busy cycles and SCL pull-down rises at each falling clock edge, and on done it compares them against the head of the queue. A model of the bus device changes SDA only on SCL falls and captures it on SCL releases, so data is checked at the exact phase in which the design must hold it.

// File: rtl/i2c_xfer_pkg.sv
package i2c_xfer_pkg;
   // Sequencer phase: SCL low, SCL high, closing low phase
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2,
      PH_TAIL = 2'd3
   } phase_e;

   localparam int CODE_W_DEF     = 3;
   localparam int MAX_CODE_DEF   = 6;
   localparam int EXP_BASE_DEF   = 4;
   localparam int HIGH_EXTRA_DEF = 4;
endpackage

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
   parameter int CODE_W     = i2c_xfer_pkg::CODE_W_DEF,
   parameter int MAX_CODE   = i2c_xfer_pkg::MAX_CODE_DEF,
   parameter int EXP_BASE   = i2c_xfer_pkg::EXP_BASE_DEF,
   parameter int HIGH_EXTRA = i2c_xfer_pkg::HIGH_EXTRA_DEF,
   localparam int MAX_LO    = 1 << (MAX_CODE + EXP_BASE - 1),
   localparam int CNT_W     = $clog2(MAX_LO + HIGH_EXTRA + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              hi_phase,
   input  logic [CODE_W-1:0] code,
   input  logic              scl_in,
   output logic              phase_end,
   output logic              sample_stb
);
   if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_code
      $error("i2c_scl_timer: MAX_CODE does not fit in CODE_W");
   end
   if (EXP_BASE < 1) begin : g_bad_base
      $error("i2c_scl_timer: EXP_BASE must be at least 1");
   end

   logic [CODE_W-1:0] eff_code;
   logic [CNT_W-1:0]  lo_len, hi_len, limit, cnt;
   logic              advance;

   // Reserved codes above MAX_CODE fold onto the slowest rate
   always_comb begin
      eff_code = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
      lo_len   = CNT_W'(1) << (int'(eff_code) + EXP_BASE - 1);
   end

   if (HIGH_EXTRA == 0) begin : g_sym
      assign hi_len = lo_len;
   end else begin : g_asym
      assign hi_len = lo_len + CNT_W'(HIGH_EXTRA);
   end

   assign limit      = hi_phase ? hi_len : lo_len;
   // High phase only advances once the wired line is really high
   assign advance    = !hi_phase || scl_in;
   assign phase_end  = run && advance && (cnt == limit - CNT_W'(1));
   assign sample_stb = run && hi_phase && scl_in && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!run || phase_end) cnt <= '0;
      else if (advance)          cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/i2c_bit_seq.sv
module i2c_bit_seq
   import i2c_xfer_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CODE_W  = CODE_W_DEF,
   localparam int BC_W   = $clog2(DATA_W),
   localparam int IDX_W  = $clog2(DATA_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rx_dir,
   input  logic [DATA_W-1:0] tx_data,
   input  logic [BC_W-1:0]   bit_cnt,
   input  logic              ack_en,
   input  logic [CODE_W-1:0] clk_code,
   input  logic              sda_in,
   input  logic              phase_end,
   input  logic              sample_stb,
   output logic [CODE_W-1:0] code_q,
   output logic              hi_phase,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_data,
   output logic              ack_bit
);
   if (DATA_W < 2 || (1 << BC_W) != DATA_W) begin : g_bad_width
      $error("i2c_bit_seq: DATA_W must be a power of two, at least 2");
   end

   phase_e            ph;
   logic [IDX_W-1:0]  idx, nbits, last;
   logic              rx_m, ack_m, in_data;
   logic [DATA_W-1:0] shreg;

   assign in_data  = idx < nbits;
   assign last     = nbits + IDX_W'(ack_m) - IDX_W'(1);
   assign busy     = (ph != PH_IDLE);
   assign hi_phase = (ph == PH_HIGH);
   assign scl_oe   = (ph == PH_LOW) || (ph == PH_TAIL);

   always_comb begin
      sda_oe = 1'b0;
      if (ph == PH_LOW || ph == PH_HIGH) begin
         if (in_data) sda_oe = !rx_m && !shreg[DATA_W-1];
         else         sda_oe = rx_m;  // receiver acknowledges
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         idx     <= '0;
         nbits   <= IDX_W'(DATA_W);
         rx_m    <= 1'b0;
         ack_m   <= 1'b0;
         code_q  <= '0;
         shreg   <= '0;
         rx_data <= '0;
         ack_bit <= 1'b1;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (ph)
            PH_IDLE: if (start) begin
               ph      <= PH_LOW;
               idx     <= '0;
               nbits   <= (bit_cnt == '0) ? IDX_W'(DATA_W) : IDX_W'(bit_cnt);
               rx_m    <= rx_dir;
               ack_m   <= ack_en;
               code_q  <= clk_code;
               shreg   <= tx_data;
               rx_data <= '0;
               ack_bit <= 1'b1;
            end
            PH_LOW: if (phase_end) ph <= PH_HIGH;
            PH_HIGH: begin
               if (sample_stb) begin
                  if (in_data) begin
                     if (rx_m) rx_data <= {rx_data[DATA_W-2:0], sda_in};
                  end else if (!rx_m) begin
                     ack_bit <= sda_in;
                  end
               end
               if (phase_end) begin
                  shreg <= {shreg[DATA_W-2:0], 1'b0};
                  if (idx == last) begin
                     ph <= PH_TAIL;
                  end else begin
                     idx <= idx + IDX_W'(1);
                     ph  <= PH_LOW;
                  end
               end
            end
            PH_TAIL: if (phase_end) begin
               ph   <= PH_IDLE;
               done <= 1'b1;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2c_xfer_engine.sv
module i2c_xfer_engine
   import i2c_xfer_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CODE_W     = CODE_W_DEF,
   parameter int MAX_CODE   = MAX_CODE_DEF,
   parameter int EXP_BASE   = EXP_BASE_DEF,
   parameter int HIGH_EXTRA = HIGH_EXTRA_DEF,
   localparam int BC_W      = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rx_dir_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   input  logic [BC_W-1:0]   bit_cnt_i,
   input  logic              ack_en_i,
   input  logic [CODE_W-1:0] clk_sel_i,
   input  logic              sda_i,
   input  logic              scl_i,
   output logic              sda_oe_o,
   output logic              scl_oe_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              ack_bit_o
);
   logic              phase_end, sample_stb, hi_phase;
   logic [CODE_W-1:0] code_q;

   i2c_bit_seq #(.DATA_W(DATA_W), .CODE_W(CODE_W)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_i),
      .rx_dir     (rx_dir_i),
      .tx_data    (tx_byte_i),
      .bit_cnt    (bit_cnt_i),
      .ack_en     (ack_en_i),
      .clk_code   (clk_sel_i),
      .sda_in     (sda_i),
      .phase_end  (phase_end),
      .sample_stb (sample_stb),
      .code_q     (code_q),
      .hi_phase   (hi_phase),
      .scl_oe     (scl_oe_o),
      .sda_oe     (sda_oe_o),
      .busy       (busy_o),
      .done       (done_o),
      .rx_data    (rx_byte_o),
      .ack_bit    (ack_bit_o)
   );

   i2c_scl_timer #(
      .CODE_W(CODE_W), .MAX_CODE(MAX_CODE),
      .EXP_BASE(EXP_BASE), .HIGH_EXTRA(HIGH_EXTRA)
   ) timer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (busy_o),
      .hi_phase   (hi_phase),
      .code       (code_q),
      .scl_in     (scl_i),
      .phase_end  (phase_end),
      .sample_stb (sample_stb)
   );
endmodule

// File: rtl/i2c_xfer_engine_chk.sv
module i2c_xfer_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic scl_i,
   input logic sda_oe_o,
   input logic scl_oe_o,
   input logic busy_o,
   input logic done_o
);
   assert_start_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o && scl_oe_o);

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   assert_sda_in_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> scl_oe_o);

   assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !scl_oe_o && !sda_oe_o);

   assert_stretch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !scl_oe_o && !scl_i |=> !scl_oe_o && busy_o);
endmodule

bind i2c_xfer_engine i2c_xfer_engine_chk chk_i (.*);

// File: tb/i2c_xfer_engine_tb_top.sv
module i2c_xfer_engine_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, rx_dir_i = 1'b0, ack_en_i = 1'b0;
   logic [7:0] tx_byte_i = '0;
   logic [2:0] bit_cnt_i = '0, clk_sel_i = '0;
   logic       sda_oe_o, scl_oe_o, busy_o, done_o, ack_bit_o;
   logic [7:0] rx_byte_o;
   logic       pull = 1'b0, stretch_r = 1'b0;
   logic       sda_line, scl_line;

   always #2 clk = ~clk;  // 250 MHz

   assign sda_line = ~(sda_oe_o | pull);
   assign scl_line = ~(scl_oe_o | stretch_r);

   i2c_xfer_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_dir_i(rx_dir_i),
      .tx_byte_i(tx_byte_i), .bit_cnt_i(bit_cnt_i), .ack_en_i(ack_en_i),
      .clk_sel_i(clk_sel_i), .sda_i(sda_line), .scl_i(scl_line),
      .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o), .busy_o(busy_o),
      .done_o(done_o), .rx_byte_o(rx_byte_o), .ack_bit_o(ack_bit_o)
   );

   typedef struct {
      int         cycles;
      int         pulses;
      bit         chk_tx;
      logic [7:0] tx_bits;
      bit         chk_rx;
      logic [7:0] rx;
      logic       ack;
      bit         chk_mack;
      bit         ack_on;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0, n_fail = 0;

   // bus device model state
   bit         s_rx, s_ack_en, s_ack_pull;
   int         s_nbits, s_idx;
   logic [7:0] s_data, tx_cap;
   logic       mack_seen;

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Device: drives SDA on each SCL pull-down, captures on each release
   initial forever begin
      @(posedge scl_oe_o);
      s_idx++;
      if (s_rx && s_idx < s_nbits)                      pull = ~s_data[s_nbits-1-s_idx];
      else if (!s_rx && s_ack_en && s_idx == s_nbits)   pull = s_ack_pull;
      else                                             pull = 1'b0;
   end
   initial forever begin
      @(negedge scl_oe_o);
      if (!s_rx && s_idx < s_nbits) tx_cap = {tx_cap[6:0], sda_line};
      if (s_rx && s_ack_en && s_idx == s_nbits) mack_seen = sda_oe_o;
   end

   // Monitor: scoreboard compare on each done pulse
   initial begin
      int cyc = 0, pls = 0;
      logic prev = 1'b0;
      forever begin
         @(negedge clk);
         if (scl_oe_o && !prev) pls++;
         prev = scl_oe_o;
         if (busy_o) cyc++;
         if (done_o) begin
            if (q.size() == 0) begin
               check("R7", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(e.tag, "busy cycles", cyc, e.cycles);
               check(e.ack_on ? "R4" : "R5", "scl pulses", pls, e.pulses);
               check(e.ack_on ? "R4" : "R5", "ack bit", int'(ack_bit_o), int'(e.ack));
               if (e.chk_tx)   check("R2", "bits on SDA", int'(tx_cap), int'(e.tx_bits));
               if (e.chk_rx)   check("R3", "rx byte", int'(rx_byte_o), int'(e.rx));
               if (e.chk_mack) check("R4", "master ack drive", int'(mack_seen), 1);
            end
            cyc = 0;
            pls = 0;
         end
      end
   end

   task automatic xfer(input bit rx, input int bc, input logic [7:0] tb, input bit ack,
                       input int code, input logic [7:0] sdat, input bit apull,
                       input int stretch, input bit interfere, input string tag);
      exp_t e;
      int k, c, lo, hi, p;
      k  = (bc == 0) ? 8 : bc;
      c  = (code > 6) ? 6 : code;
      lo = 1 << (c + 3);
      hi = lo + 4;
      p  = k + (ack ? 1 : 0);
      e.cycles   = p * (lo + hi) + lo + stretch;
      e.pulses   = p + 1;
      e.chk_tx   = !rx;
      e.tx_bits  = tb >> (8 - k);
      e.chk_rx   = rx;
      e.rx       = sdat & 8'((1 << k) - 1);
      e.ack      = (!rx && ack) ? ~apull : 1'b1;
      e.chk_mack = rx && ack;
      e.ack_on   = ack;
      e.tag      = tag;
      s_rx = rx; s_nbits = k; s_data = sdat; s_ack_en = ack; s_ack_pull = apull;
      s_idx = -1; tx_cap = '0; mack_seen = 1'b0;
      @(negedge clk);
      rx_dir_i = rx; bit_cnt_i = 3'(bc); tx_byte_i = tb; ack_en_i = ack;
      clk_sel_i = 3'(code); start_i = 1'b1;
      if (stretch > 0) stretch_r = 1'b1;
      q.push_back(e);
      @(negedge clk);
      start_i = 1'b0;
      if (stretch > 0) begin
         repeat (lo + stretch) @(posedge clk);
         @(negedge clk);
         stretch_r = 1'b0;
      end
      if (interfere) begin
         // R10 / R1: new start and new fields mid-transfer must not matter
         repeat (30) @(negedge clk);
         start_i = 1'b1; tx_byte_i = ~tb; bit_cnt_i = 3'd1; ack_en_i = ~ack;
         rx_dir_i = ~rx; clk_sel_i = 3'd3;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (busy_o) @(negedge clk);
      repeat (3) @(negedge clk);
      if (interfere) check("R1", "busy after ignored start", int'(busy_o), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy at reset", int'(busy_o), 0);
      check("R7", "done at reset", int'(done_o), 0);
      check("R8", "scl_oe at reset", int'(scl_oe_o), 0);
      check("R8", "sda_oe at reset", int'(sda_oe_o), 0);
      // R2 R4 R7: full byte sent, device acknowledges
      xfer(1'b0, 0, 8'hA5, 1'b1, 0, 8'h00, 1'b1, 0, 1'b0, "R7");
      // R2 R4: 3 bits, device does not acknowledge
      xfer(1'b0, 3, 8'hC7, 1'b1, 0, 8'h00, 1'b0, 0, 1'b0, "R7");
      // R3 R4: receive a full byte and acknowledge it
      xfer(1'b1, 0, 8'h00, 1'b1, 0, 8'h3C, 1'b0, 0, 1'b0, "R7");
      // R3 R5: receive 5 bits, no acknowledge pulse
      xfer(1'b1, 5, 8'h00, 1'b0, 0, 8'h15, 1'b0, 0, 1'b0, "R5");
      // R5 R6: one bit sent at code 1
      xfer(1'b0, 1, 8'h80, 1'b0, 1, 8'h00, 1'b0, 0, 1'b0, "R6");
      // R6: slowest code and reserved code 7
      xfer(1'b0, 1, 8'h00, 1'b0, 6, 8'h00, 1'b0, 0, 1'b0, "R6");
      xfer(1'b0, 1, 8'h80, 1'b0, 7, 8'h00, 1'b0, 0, 1'b0, "R6");
      // R9: device stretches the first high phase by 5 cycles
      xfer(1'b0, 0, 8'h5A, 1'b1, 0, 8'h00, 1'b1, 5, 1'b0, "R9");
      // R10 R1: ignored start and field changes while busy
      xfer(1'b0, 0, 8'h96, 1'b1, 0, 8'h00, 1'b1, 0, 1'b1, "R10");
      check("R7", "scoreboard empty", q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule